// File: doc/BRIEF.md
# Double-Edge Serial Frame Receiver

This block takes a serial data line together with the clock that the sender forwards alongside it, and rebuilds parallel words from that pair. The clock is edge-aligned with the data and carries one bit on each of its edges. A bit is captured on the falling edge and the next one on the following rising edge, so every clock period delivers a pair of bits into the block. A frame is thirteen such pairs, or 26 bits. It opens with a two-bit start marker and closes with a two-bit end marker, and the 22 bits in between are payload.

The receiver slides a 26-bit window over the incoming pairs and looks for a window whose first two bits and last two bits both match the markers. Once it finds one, it stops searching for the rest of that frame's length. It then loads the payload into the output word and, one clock later, pulses a one-cycle strobe. When the sender is idle, no frames arrive and nothing is produced. A power enable clears the block and holds it quiet. An output enable drives a pad-enable signal that a chip-level tristate buffer can use, and it zeroes the word while the pads are off.

Top module: `ddr_frame_deser`

## Requirements
- R1: The bit on `sdata_i` at a falling edge of `sclk_i` is frame bit 2k-1, and the bit at the following rising edge is frame bit 2k (k = 1..13). Bit 1 of a frame is the first bit sent.
- R2: A frame is accepted only when bit 1 = 1, bit 2 = 0, bit 25 = 0 and bit 26 = 1. A frame with any of these four bits inverted produces no strobe and leaves `word_o` unchanged.
- R3: For an accepted frame, `word_o[i]` equals frame bit 3+i, for i = 0..21.
- R4: If bit 26 is captured at rising edge P, then `word_o` takes the new value after edge P+1, and `strobe_o` is high for exactly the one cycle that follows edge P+2.
- R5: `word_o` holds its value until the next accepted frame. While the line is idle (all zeros), `strobe_o` stays low.
- R6: Frames sent back to back with no idle gap each yield one word, in order. After an acceptance, marker matches are ignored for the next 12 rising edges.
- R7: While `en_i` is low, all state is cleared: `strobe_o` stays low, `word_o` reads zero, and frames sent during that time are never output.
- R8: `pad_oe_o` equals `en_i & oe_i`. While `pad_oe_o` is low, `word_o` reads zero, but reception continues: raising `oe_i` shows the last word received.
- R9: After reset, `word_o` is zero and `strobe_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Forwarded serial clock; data is captured on both edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Power enable; low clears and idles the block |
| oe_i | input | 1 | Output-pad enable request |
| sdata_i | input | 1 | Serial data line |
| word_o | output | 22 | Last recovered payload word |
| strobe_o | output | 1 | One-cycle pulse, one cycle after `word_o` updates |
| pad_oe_o | output | 1 | Enable for the chip-level tristate drivers of the word pads |

## Verification
The bench builds the receiver with its default of 13 bit pairs per frame, which gives a 22-bit payload. At that size the bench can place a walking one and a walking zero at every payload position, inverting each of the four marker bits, and send a long pseudo-random series with and without idle gaps. These patterns expose any swap between the falling-edge and rising-edge bits, any bit-order error, and any lost or extra word when frames abut. A scoreboard predicts the cycle of every word change and every strobe from the end of each frame. As a result, the timing rules, the hold rule and the power and pad controls are all checked at the edge where they take effect.

// File: rtl/ddrdes_pkg.sv
package ddrdes_pkg;
  localparam logic [1:0] HEAD_MARK = 2'b10; // first bit 1, second bit 0
  localparam logic [1:0] TAIL_MARK = 2'b01; // second-to-last 0, last 1

  function automatic logic markers_match(input logic [1:0] head, input logic [1:0] tail);
    return (head == HEAD_MARK) && (tail == TAIL_MARK);
  endfunction
endpackage

// File: rtl/ddr_bit_capture.sv
module ddr_bit_capture (
  input  logic       sclk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sdata_i,
  output logic [1:0] pair_o
);
  logic fall_q;

  // odd bit, taken on the falling edge
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)    fall_q <= 1'b0;
    else if (!en_i) fall_q <= 1'b0;
    else            fall_q <= sdata_i;
  end

  // pair as seen at the rising edge: {odd, even}
  assign pair_o = {fall_q, sdata_i};
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_PAIRS = 13
) (
  input  logic                    sclk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [1:0]              pair_i,
  output logic                    hit_o,
  output logic [2*FRAME_PAIRS-5:0] payload_o
);
  import ddrdes_pkg::*;
  localparam int FBITS = 2 * FRAME_PAIRS;
  localparam int WW    = FBITS - 4;

  logic [FBITS-1:0] win_q;

  // win_q[FBITS-1] holds the oldest bit (frame bit 1)
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (!en_i) win_q <= '0;
    else            win_q <= {win_q[FBITS-3:0], pair_i};
  end

  // payload bit i is frame bit 3+i, stored at win_q[FBITS-3-i]
  function automatic logic [WW-1:0] take_payload(input logic [FBITS-1:0] w);
    logic [WW-1:0] r;
    for (int i = 0; i < WW; i++) r[i] = w[FBITS-3-i];
    return r;
  endfunction

  assign hit_o     = markers_match(win_q[FBITS-1:FBITS-2], win_q[1:0]);
  assign payload_o = take_payload(win_q);
endmodule

// File: rtl/word_output_stage.sv
module word_output_stage #(
  parameter int FRAME_PAIRS = 13,
  parameter int WORD_W      = 22
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic [WORD_W-1:0] payload_i,
  output logic              busy_o,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o,
  output logic              strobe_o
);
  localparam int CNT_W = $clog2(FRAME_PAIRS);
  localparam logic [CNT_W-1:0] HOLD_N = CNT_W'(FRAME_PAIRS - 1);

  logic [CNT_W-1:0]  lock_q;
  logic              load_q, strobe_q;
  logic [WORD_W-1:0] word_q;
  logic              accept;

  assign busy_o = (lock_q != '0);
  assign accept = hit_i && !busy_o;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0; load_q <= 1'b0; strobe_q <= 1'b0; word_q <= '0;
    end else if (!en_i) begin
      lock_q <= '0; load_q <= 1'b0; strobe_q <= 1'b0; word_q <= '0;
    end else begin
      load_q   <= accept;
      strobe_q <= load_q;
      if (accept) begin
        word_q <= payload_i;
        lock_q <= HOLD_N;
      end else if (busy_o) begin
        lock_q <= lock_q - 1'b1;
      end
    end
  end

  assign load_o   = load_q;
  assign word_o   = word_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/ddr_frame_deser.sv
module ddr_frame_deser #(
  parameter int FRAME_PAIRS = 13
) (
  input  logic                     sclk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     oe_i,
  input  logic                     sdata_i,
  output logic [2*FRAME_PAIRS-5:0] word_o,
  output logic                     strobe_o,
  output logic                     pad_oe_o
);
  localparam int WORD_W = 2 * FRAME_PAIRS - 4;

  logic [1:0]        bit_pair;
  logic              frame_hit;
  logic [WORD_W-1:0] payload;
  logic              lock_busy;
  logic              word_load;
  logic [WORD_W-1:0] word_q;
  logic              strobe_q;

  ddr_bit_capture i_cap (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .en_i(en_i), .sdata_i(sdata_i), .pair_o(bit_pair)
  );

  frame_shifter #(.FRAME_PAIRS(FRAME_PAIRS)) i_shift (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .en_i(en_i), .pair_i(bit_pair),
    .hit_o(frame_hit), .payload_o(payload)
  );

  word_output_stage #(.FRAME_PAIRS(FRAME_PAIRS), .WORD_W(WORD_W)) i_out (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .en_i(en_i), .hit_i(frame_hit),
    .payload_i(payload), .busy_o(lock_busy), .load_o(word_load),
    .word_o(word_q), .strobe_o(strobe_q)
  );

  assign pad_oe_o = en_i & oe_i;
  assign word_o   = pad_oe_o ? word_q : '0;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/ddr_frame_deser_checker.sv
module ddr_frame_deser_checker #(
  parameter int WORD_W = 22
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              frame_hit,
  input logic              lock_busy,
  input logic              word_load,
  input logic [WORD_W-1:0] word_q,
  input logic              strobe_q,
  input logic              pad_oe_o,
  input logic [WORD_W-1:0] word_o
);
  a_r4_strobe_follows_load: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (en_i && word_load) |=> strobe_q);

  a_r4_strobe_single: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);

  a_r5_word_holds: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (en_i && !(frame_hit && !lock_busy)) |=> (word_q == $past(word_q)));

  a_r6_lockout_blocks: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (frame_hit && lock_busy) |=> !word_load);

  a_r6_free_hit_loads: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (en_i && frame_hit && !lock_busy) |=> word_load);

  a_r7_quiet_when_off: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !en_i |=> (!strobe_q && word_q == '0));

  a_r8_pads_off_zero: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !pad_oe_o |-> (word_o == '0));
endmodule

bind ddr_frame_deser ddr_frame_deser_checker #(.WORD_W(WORD_W)) i_chk (
  .sclk_i(sclk_i), .rst_ni(rst_ni), .en_i(en_i), .frame_hit(frame_hit),
  .lock_busy(lock_busy), .word_load(word_load), .word_q(word_q),
  .strobe_q(strobe_q), .pad_oe_o(pad_oe_o), .word_o(word_o)
);

// File: tb/test_ddr_frame_deser.sv
module test_ddr_frame_deser;
  localparam int CLK_PERIOD = 10;
  localparam int PAIRS = 13;
  localparam int WW = 2 * PAIRS - 4;

  logic sclk = 1'b0, rst_n = 1'b0, en = 1'b1, oe = 1'b1, sdata = 1'b0;
  logic [WW-1:0] word;
  logic strobe, pad_oe;

  int checks = 0, errors = 0, cyc = 0;
  logic [WW-1:0] exp_w [0:511];
  int exp_c [0:511];
  int qh = 0, qt = 0;
  logic mon_on = 1'b0;
  logic [WW-1:0] prev_word = '0;
  logic [WW-1:0] last_sent = '0;

  ddr_frame_deser i_ddr_frame_deser (
    .sclk_i(sclk), .rst_ni(rst_n), .en_i(en), .oe_i(oe), .sdata_i(sdata),
    .word_o(word), .strobe_o(strobe), .pad_oe_o(pad_oe)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;
  always @(posedge sclk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame bits 1..26: markers around payload, payload bit i is frame bit 3+i (R1, R3)
  function automatic logic [26:1] make_frame(input logic [WW-1:0] w);
    logic [26:1] f;
    f[1] = 1'b1; f[2] = 1'b0; f[25] = 1'b0; f[26] = 1'b1;
    for (int i = 0; i < WW; i++) f[3+i] = w[i];
    return f;
  endfunction

  task automatic send_bits(input logic [26:1] f, input bit expect_word, input logic [WW-1:0] w);
    for (int k = 1; k <= PAIRS; k++) begin
      @(posedge sclk); #2 sdata = f[2*k-1];
      @(negedge sclk); #2 sdata = f[2*k];
    end
    if (expect_word) begin
      exp_w[qt] = w; exp_c[qt] = cyc + 3; qt++;
      last_sent = w;
    end
  endtask

  task automatic send_word(input logic [WW-1:0] w);
    send_bits(make_frame(w), 1'b1, w);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge sclk); #2 sdata = 1'b0;
      @(negedge sclk); #2 sdata = 1'b0;
    end
  endtask

  // scoreboard: R4 timing, R5 hold, R6 no loss
  always @(negedge sclk) begin
    if (mon_on) begin
      if (strobe) begin
        if (qh == qt) check(1'b0, "R5 unexpected strobe", 32'(word), 32'h0);
        else begin
          check(word == exp_w[qh], "R3 word at strobe", 32'(word), 32'(exp_w[qh]));
          check(cyc == exp_c[qh], "R4 strobe cycle", 32'(cyc), 32'(exp_c[qh]));
          check(prev_word == exp_w[qh], "R4 word one cycle before strobe", 32'(prev_word), 32'(exp_w[qh]));
          qh++;
        end
      end else if (word != prev_word) begin
        if (qh == qt) check(1'b0, "R5 word changed without frame", 32'(word), 32'(prev_word));
        else check(exp_c[qh] == cyc + 1 && word == exp_w[qh], "R5 word change timing",
                   32'(word), 32'(exp_w[qh]));
      end
    end
    prev_word = word;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] lfsr;
    repeat (3) @(posedge sclk);
    #2 rst_n = 1'b1;
    @(negedge sclk);
    check(word == '0, "R9 reset word", 32'(word), 32'h0);
    check(strobe == 1'b0, "R9 reset strobe", 32'(strobe), 32'h0);
    check(pad_oe == 1'b1, "R8 pad enable", 32'(pad_oe), 32'h1);
    mon_on = 1'b1;
    idle(3);

    // R1 R3: walking one, back to back (R6)
    for (int i = 0; i < WW; i++) send_word(WW'(1) << i);
    idle(4);
    // walking zero with gaps
    for (int i = 0; i < WW; i++) begin send_word(~(WW'(1) << i)); idle(i % 3); end
    send_word('0); idle(2);
    send_word('1); idle(20);
    check(word == '1, "R5 word held over idle", 32'(word), 32'h3fffff);

    // R2: each marker bit inverted -> dropped
    for (int m = 0; m < 4; m++) begin
      logic [26:1] f;
      int pos;
      pos = (m < 2) ? m + 1 : m + 23;
      f = make_frame(22'h2a5a5a);
      f[pos] = ~f[pos];
      idle(14);
      send_bits(f, 1'b0, '0);
      idle(14);
      check(word == '1, "R2 bad marker ignored", 32'(word), 32'h3fffff);
    end

    // R6: pseudo-random series, mixed gaps
    lfsr = 22'h1ace5;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[20:0], lfsr[21] ^ lfsr[20]};
      send_word(lfsr);
      if (n % 4 == 3) idle(n % 5);
    end
    idle(5);
    check(qh == qt, "R6 every frame produced a word", 32'(qt - qh), 32'h0);

    // R8: pads off
    mon_on = 1'b0;
    oe = 1'b0;
    @(negedge sclk);
    check(pad_oe == 1'b0, "R8 pad enable low", 32'(pad_oe), 32'h0);
    check(word == '0, "R8 word zero when pads off", 32'(word), 32'h0);
    send_bits(make_frame(22'h0c3c3c), 1'b0, '0);
    idle(5);
    check(word == '0, "R8 word still zero", 32'(word), 32'h0);
    oe = 1'b1;
    @(negedge sclk);
    check(word == 22'h0c3c3c, "R8 received while pads off", 32'(word), 32'h0c3c3c);

    // R7: power enable low
    en = 1'b0;
    @(negedge sclk);
    @(negedge sclk);
    check(word == '0 && pad_oe == 1'b0, "R7 cleared when off", 32'(word), 32'h0);
    for (int k = 0; k < 3; k++) begin
      send_bits(make_frame(22'h155555), 1'b0, '0);
      @(negedge sclk);
      check(strobe == 1'b0 && word == '0, "R7 no output when off", 32'(word), 32'h0);
    end
    idle(4);
    check(word == '0, "R7 nothing kept", 32'(word), 32'h0);
    en = 1'b1;
    idle(2);
    mon_on = 1'b1;
    send_word(22'h3a0f51); idle(6);
    check(word == 22'h3a0f51, "R7 works after re-enable", 32'(word), 32'h3a0f51);
    check(qh == qt, "R6 queue drained", 32'(qt - qh), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule